// File: doc/BRIEF.md
# SERDES Power and Reset Sequencer

This controller runs the power-up, power-down and reset sequences for one SERDES lane and its PLL. It takes three single-cycle command inputs: power-up, power-down and reset. It drives three 3-bit state fields, one each for the PLL, the transmitter and the receiver, plus a power-on-reset enable line. It watches two status inputs, PLL lock and common-module ready.

Power-up is a two-stage handshake. The PLL is enabled and its lock flag is polled until it reads 1. Then the transmitter and the receiver are enabled in turn, and the ready flag is polled. Each poll has its own interval and its own timeout. Power-down and reset each step through a fixed order. Reset ends with a power-on-reset pulse of fixed length.

All times are counted in microsecond ticks. The tick is produced by dividing the clock by a parameter. The poll intervals, the timeouts and the pulse width are parameters too, so they can be scaled down.

Top module: `serdes_pwr_seq`

## Requirements
- R1: While the synchronous active-high `rst` input is high, and in the cycle after it is released, all three state fields read 3'b100, `por_en` is low, and `busy`, `done` and `timeout_err` are low. Asserting `rst` during a sequence abandons that sequence.
- R2: The state fields use these codes: 3'b100 = off, 3'b101 = sleep, 3'b110 = snooze, 3'b111 = on. This block only ever drives 3'b100 or 3'b111.
- R3: Power-up steps, one register update per step:
  - In the cycle after the command is accepted, the PLL field becomes 3'b111.
  - The TX field becomes 3'b111 only at the clock edge where `pll_ok` is sampled as 1.
  - The RX field becomes 3'b111 one cycle after the TX field.
- R4: The lock poll samples `pll_ok` in two kinds of cycle. The first is the first cycle after the PLL is switched on. The second is every cycle in which the tick count since then reaches a multiple of PLL_POLL_US. Between these sample cycles, the value of `pll_ok` has no effect.
- R5: Suppose `pll_ok` has not been sampled as 1 by the tick that brings the count to PLL_TMO_US. At that tick the sequence stops and `timeout_err` rises. TX and RX stay at 3'b100, and no `done` pulse is given.
- R6: After RX is switched on, `cmu_ok` is polled the same way, using CMU_POLL_US and CMU_TMO_US. Power-up completes only when `cmu_ok` is sampled as 1. On a timeout, the sequence stops with `timeout_err` set and no `done` pulse.
- R7: Power-down sets the TX field to 3'b100, then the RX field, then the PLL field, one cycle apart.
- R8: Reset proceeds in this order, one cycle apart:
  - It sets the PLL field to 3'b100, then TX, then RX.
  - It then raises `por_en`.
  - `por_en` stays high until the POR_US-th tick after it rises, and then drops.
- R9: A command is accepted only while `busy` is low; a command that arrives while `busy` is high has no effect. If several commands arrive in the same idle cycle, reset wins over power-down, and power-down wins over power-up.
- R10: When a sequence finishes, `done` is high for exactly one cycle and `busy` is low in that same cycle. `timeout_err` stays high until the next command is accepted, which clears it.
- R11: A microsecond tick occurs every CLK_PER_US clock cycles. The first tick falls CLK_PER_US cycles after `rst` is released, and the count restarts whenever `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| pwr_on_req | input | 1 | Power-up command pulse |
| pwr_off_req | input | 1 | Power-down command pulse |
| rst_req | input | 1 | SERDES reset command pulse |
| pll_ok | input | 1 | PLL lock status |
| cmu_ok | input | 1 | Common-module ready status |
| pll_state | output | 3 | PLL state field |
| tx_state | output | 3 | Transmit lane state field |
| rx_state | output | 3 | Receive lane state field |
| por_en | output | 1 | Power-on-reset enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Poll timeout flag, held until next command |

## Verification
The assertions assume that `rst` is held high for at least two clock edges before any checked cycle. This lets every `$past` term see reset values. The bench meets this by starting in reset for several cycles, and by pulsing reset mid-run for two cycles only.

The status inputs need not be synchronous to the sample points. The bench toggles `pll_ok` and `cmu_ok` freely between sample cycles. Commands are single-cycle pulses driven on the falling edge, and some of them are deliberately issued while `busy` is high.

// File: rtl/serdes_seq_pkg.sv
package serdes_seq_pkg;

   typedef enum logic [2:0] {
      LS_OFF = 3'b100,
      LS_SLP = 3'b101,
      LS_SNZ = 3'b110,
      LS_ON  = 3'b111
   } lane_st_e;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_PLL_WAIT,
      SQ_PON_RX,
      SQ_CMU_WAIT,
      SQ_OFF_RX,
      SQ_OFF_PLL,
      SQ_RST_TX,
      SQ_RST_RX,
      SQ_POR_ON,
      SQ_POR_HOLD
   } seq_st_e;

endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
   parameter int DIV = 50
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   if (DIV < 1) begin : g_bad_div
      $error("us_tick_gen: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick_o = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      logic          wrap;

      assign wrap   = (cnt_q == CW'(DIV - 1));
      assign tick_o = wrap;

      always_ff @(posedge clk) begin
         if (rst)       cnt_q <= '0;
         else if (wrap) cnt_q <= '0;
         else           cnt_q <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
   parameter int INTV = 1000,
   parameter int TMO  = 100000
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic run_i,
   input  logic tick_i,
   output logic sample_o,
   output logic final_o
);
   if (INTV < 1 || TMO < INTV) begin : g_bad_cfg
      $error("poll_timer: need 1 <= INTV <= TMO");
   end

   localparam int EW = $clog2(TMO + 1);
   localparam int IW = $clog2(INTV + 1);

   logic [EW-1:0] el_q;
   logic [IW-1:0] iv_q;
   logic          first_q;
   logic          ival_hit;

   assign ival_hit = tick_i && (iv_q == IW'(INTV - 1));
   assign final_o  = run_i && tick_i && (el_q == EW'(TMO - 1));
   assign sample_o = run_i && (first_q || ival_hit || final_o);

   always_ff @(posedge clk) begin
      if (rst || start_i) begin
         el_q    <= '0;
         iv_q    <= '0;
         first_q <= start_i && !rst;
      end else if (run_i) begin
         first_q <= 1'b0;
         if (tick_i) begin
            if (el_q != EW'(TMO)) el_q <= el_q + EW'(1);
            iv_q <= ival_hit ? '0 : iv_q + IW'(1);
         end
      end
   end

   // R5
   el_bound_chk: assert property (@(posedge clk) disable iff (rst)
      final_o |=> (el_q == EW'(TMO)) || first_q || !run_i);
endmodule

// File: rtl/serdes_pwr_seq.sv
module serdes_pwr_seq
   import serdes_seq_pkg::*;
#(
   parameter int CLK_PER_US  = 50,
   parameter int PLL_POLL_US = 1000,
   parameter int PLL_TMO_US  = 100000,
   parameter int CMU_POLL_US = 100,
   parameter int CMU_TMO_US  = 100000,
   parameter int POR_US      = 1000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       pwr_on_req,
   input  logic       pwr_off_req,
   input  logic       rst_req,
   input  logic       pll_ok,
   input  logic       cmu_ok,
   output logic [2:0] pll_state,
   output logic [2:0] tx_state,
   output logic [2:0] rx_state,
   output logic       por_en,
   output logic       busy,
   output logic       done,
   output logic       timeout_err
);
   seq_st_e  st_q;
   lane_st_e pll_q, tx_q, rx_q;
   logic     por_q, done_q, err_q;
   logic     tick;
   logic     take_on;
   logic     pll_smp, pll_fin, cmu_smp, cmu_fin, por_smp, por_fin;

   us_tick_gen #(.DIV(CLK_PER_US)) u_tick (
      .clk(clk), .rst(rst), .tick_o(tick));

   // Idle-cycle priority: reset, then power-down, then power-up.
   assign take_on = (st_q == SQ_IDLE) && pwr_on_req && !pwr_off_req && !rst_req;

   poll_timer #(.INTV(PLL_POLL_US), .TMO(PLL_TMO_US)) u_pll_poll (
      .clk(clk), .rst(rst), .start_i(take_on),
      .run_i(st_q == SQ_PLL_WAIT), .tick_i(tick),
      .sample_o(pll_smp), .final_o(pll_fin));

   poll_timer #(.INTV(CMU_POLL_US), .TMO(CMU_TMO_US)) u_cmu_poll (
      .clk(clk), .rst(rst), .start_i(st_q == SQ_PON_RX),
      .run_i(st_q == SQ_CMU_WAIT), .tick_i(tick),
      .sample_o(cmu_smp), .final_o(cmu_fin));

   poll_timer #(.INTV(POR_US), .TMO(POR_US)) u_por_hold (
      .clk(clk), .rst(rst), .start_i(st_q == SQ_POR_ON),
      .run_i(st_q == SQ_POR_HOLD), .tick_i(tick),
      .sample_o(por_smp), .final_o(por_fin));

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= SQ_IDLE;
         pll_q  <= LS_OFF;
         tx_q   <= LS_OFF;
         rx_q   <= LS_OFF;
         por_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               if (rst_req) begin
                  err_q <= 1'b0;
                  pll_q <= LS_OFF;
                  st_q  <= SQ_RST_TX;
               end else if (pwr_off_req) begin
                  err_q <= 1'b0;
                  tx_q  <= LS_OFF;
                  st_q  <= SQ_OFF_RX;
               end else if (pwr_on_req) begin
                  err_q <= 1'b0;
                  pll_q <= LS_ON;
                  st_q  <= SQ_PLL_WAIT;
               end
            end
            SQ_PLL_WAIT: begin
               if (pll_smp && pll_ok) begin
                  tx_q <= LS_ON;
                  st_q <= SQ_PON_RX;
               end else if (pll_fin) begin
                  err_q <= 1'b1;
                  st_q  <= SQ_IDLE;
               end
            end
            SQ_PON_RX: begin
               rx_q <= LS_ON;
               st_q <= SQ_CMU_WAIT;
            end
            SQ_CMU_WAIT: begin
               if (cmu_smp && cmu_ok) begin
                  done_q <= 1'b1;
                  st_q   <= SQ_IDLE;
               end else if (cmu_fin) begin
                  err_q <= 1'b1;
                  st_q  <= SQ_IDLE;
               end
            end
            SQ_OFF_RX: begin
               rx_q <= LS_OFF;
               st_q <= SQ_OFF_PLL;
            end
            SQ_OFF_PLL: begin
               pll_q  <= LS_OFF;
               done_q <= 1'b1;
               st_q   <= SQ_IDLE;
            end
            SQ_RST_TX: begin
               tx_q <= LS_OFF;
               st_q <= SQ_RST_RX;
            end
            SQ_RST_RX: begin
               rx_q <= LS_OFF;
               st_q <= SQ_POR_ON;
            end
            SQ_POR_ON: begin
               por_q <= 1'b1;
               st_q  <= SQ_POR_HOLD;
            end
            SQ_POR_HOLD: begin
               if (por_smp && por_fin) begin
                  por_q  <= 1'b0;
                  done_q <= 1'b1;
                  st_q   <= SQ_IDLE;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign pll_state   = pll_q;
   assign tx_state    = tx_q;
   assign rx_state    = rx_q;
   assign por_en      = por_q;
   assign busy        = (st_q != SQ_IDLE);
   assign done        = done_q;
   assign timeout_err = err_q;

   // R2
   field_codes_chk: assert property (@(posedge clk) disable iff (rst)
      (pll_state == LS_OFF || pll_state == LS_ON) &&
      (tx_state  == LS_OFF || tx_state  == LS_ON) &&
      (rx_state  == LS_OFF || rx_state  == LS_ON));

   // R3
   tx_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_state == LS_ON && $past(tx_state) != LS_ON) |->
         (pll_state == LS_ON && $past(pll_ok)));

   // R3
   rx_after_tx_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_state == LS_ON && $past(rx_state) != LS_ON) |-> ($past(tx_state) == LS_ON));

   // R8
   por_lanes_off_chk: assert property (@(posedge clk) disable iff (rst)
      por_en |-> (pll_state == LS_OFF && tx_state == LS_OFF && rx_state == LS_OFF));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R10
   flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (done || timeout_err) |-> !busy);
endmodule

// File: tb/sim_serdes_pwr_seq.sv
module sim_serdes_pwr_seq;
   localparam int CPU = 4;
   localparam int PP  = 10;
   localparam int PT  = 50;
   localparam int CP  = 3;
   localparam int CT  = 20;
   localparam int PR  = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pwr_on_req = 1'b0, pwr_off_req = 1'b0, rst_req = 1'b0;
   logic pll_ok = 1'b0, cmu_ok = 1'b0;
   logic [2:0] pll_state, tx_state, rx_state;
   logic por_en, busy, done, timeout_err;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   bit started = 1'b0;
   bit finished = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   serdes_pwr_seq #(
      .CLK_PER_US(CPU), .PLL_POLL_US(PP), .PLL_TMO_US(PT),
      .CMU_POLL_US(CP), .CMU_TMO_US(CT), .POR_US(PR)
   ) u0 (
      .clk(clk), .rst(rst), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
      .rst_req(rst_req), .pll_ok(pll_ok), .cmu_ok(cmu_ok),
      .pll_state(pll_state), .tx_state(tx_state), .rx_state(rx_state),
      .por_en(por_en), .busy(busy), .done(done), .timeout_err(timeout_err));

   // Behavioural reference: 0 idle, 1 lock wait, 2 rx on, 3 ready wait,
   // 4/5 power-down steps, 6/7/8 reset steps, 9 pulse hold.
   int m_st, m_div, m_e;
   bit m_first, m_por, m_done, m_err;
   logic [2:0] m_pll, m_tx, m_rx;

   always @(posedge clk) begin
      bit tk, smp, fin, dn, ok;
      int iv, to;
      if (rst) begin
         m_st = 0; m_div = 0; m_e = 0; m_first = 0;
         m_pll = 3'h4; m_tx = 3'h4; m_rx = 3'h4;
         m_por = 0; m_done = 0; m_err = 0;
      end else begin
         tk = (m_div == CPU - 1);
         m_div = tk ? 0 : m_div + 1;
         dn = 0;
         case (m_st)
            0: begin
               if (rst_req) begin m_err = 0; m_pll = 3'h4; m_st = 6; end
               else if (pwr_off_req) begin m_err = 0; m_tx = 3'h4; m_st = 4; end
               else if (pwr_on_req) begin
                  m_err = 0; m_pll = 3'h7; m_st = 1; m_e = 0; m_first = 1;
               end
            end
            1, 3: begin
               iv = (m_st == 1) ? PP : CP;
               to = (m_st == 1) ? PT : CT;
               ok = (m_st == 1) ? pll_ok : cmu_ok;
               fin = tk && (m_e == to - 1);
               smp = m_first || (tk && ((m_e + 1) % iv == 0)) || fin;
               m_first = 0;
               if (tk && m_e < to) m_e = m_e + 1;
               if (smp && ok) begin
                  if (m_st == 1) begin m_tx = 3'h7; m_st = 2; end
                  else begin m_st = 0; dn = 1; end
               end else if (fin) begin
                  m_err = 1; m_st = 0;
               end
            end
            2: begin m_rx = 3'h7; m_st = 3; m_e = 0; m_first = 1; end
            4: begin m_rx = 3'h4; m_st = 5; end
            5: begin m_pll = 3'h4; m_st = 0; dn = 1; end
            6: begin m_tx = 3'h4; m_st = 7; end
            7: begin m_rx = 3'h4; m_st = 8; end
            8: begin m_por = 1; m_st = 9; m_e = 0; end
            9: if (tk) begin
                  if (m_e == PR - 1) begin m_por = 0; m_st = 0; dn = 1; end
                  else m_e = m_e + 1;
               end
            default: m_st = 0;
         endcase
         m_done = dn;
      end
   end

   task automatic chk(input string tag, input string what, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         miscompares++;
         $display("FAIL %s %s got %0h exp %0h at cycle %0d", tag, what, got, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (started && !finished) begin
         chk(cur_req, "pll_state", pll_state, m_pll);
         chk(cur_req, "tx_state", tx_state, m_tx);
         chk(cur_req, "rx_state", rx_state, m_rx);
         chk(cur_req, "por_en", por_en, m_por);
         chk(cur_req, "busy", busy, m_st != 0);
         chk(cur_req, "done", done, m_done);
         chk(cur_req, "timeout_err", timeout_err, m_err);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 2) started = 1'b1;
      if (cyc > 150000 && !finished) begin
         miscompares++;
         $display("FAIL R10 watchdog got hang exp finish");
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic pulse(input int which);
      @(negedge clk);
      if (which == 0) pwr_on_req = 1'b1;
      if (which == 1) pwr_off_req = 1'b1;
      if (which == 2) rst_req = 1'b1;
      @(negedge clk);
      pwr_on_req = 1'b0; pwr_off_req = 1'b0; rst_req = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (busy && n < 5000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset values
      cur_req = "R1";
      chk("R1", "reset pll", pll_state, 3'h4);
      chk("R1", "reset por", por_en, 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "idle busy", busy, 0);

      // R3/R4/R11: power-up with a noisy lock flag, power-down request ignored (R9)
      cur_req = "R3";
      pulse(0);
      for (int i = 0; i < 170; i++) begin
         @(negedge clk);
         pll_ok = (i >= 125) || (i % 9 == 4);
         cmu_ok = (i > 160) || (i % 13 == 7);
         if (i == 20) begin cur_req = "R9"; pwr_off_req = 1'b1; end
         else pwr_off_req = 1'b0;
         if (i == 40) cur_req = "R4";
         if (i == 80) cur_req = "R11";
      end
      cur_req = "R6";
      wait_idle();
      chk("R2", "on pll", pll_state, 3'h7);
      chk("R2", "on tx", tx_state, 3'h7);
      chk("R2", "on rx", rx_state, 3'h7);

      // R7: power-down, with a power-up request while busy (R9)
      cur_req = "R7";
      pulse(1);
      @(negedge clk); pwr_on_req = 1'b1;
      @(negedge clk); pwr_on_req = 1'b0;
      wait_idle();
      chk("R7", "off pll", pll_state, 3'h4);

      // R5: lock never arrives
      cur_req = "R5";
      pll_ok = 1'b0; cmu_ok = 1'b0;
      pulse(0);
      wait_idle();
      cur_req = "R10";
      repeat (10) @(negedge clk);
      chk("R10", "err held", timeout_err, 1);

      // R6: lock arrives, ready never does
      cur_req = "R6";
      pll_ok = 1'b1;
      pulse(0);
      wait_idle();
      chk("R6", "ready timeout", timeout_err, 1);

      // R8 and R9 priority: all three commands at once
      cur_req = "R8";
      @(negedge clk);
      pwr_on_req = 1'b1; pwr_off_req = 1'b1; rst_req = 1'b1;
      @(negedge clk);
      pwr_on_req = 1'b0; pwr_off_req = 1'b0; rst_req = 1'b0;
      wait_idle();
      chk("R8", "reset por low", por_en, 0);

      // R9: power-down beats power-up
      cur_req = "R9";
      @(negedge clk);
      pwr_on_req = 1'b1; pwr_off_req = 1'b1;
      @(negedge clk);
      pwr_on_req = 1'b0; pwr_off_req = 1'b0;
      wait_idle();

      // R1: controller reset mid-sequence
      cur_req = "R1";
      pll_ok = 1'b0;
      pulse(0);
      repeat (30) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      chk("R1", "abandon busy", busy, 0);
      chk("R1", "abandon pll", pll_state, 3'h4);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule